// File: doc/BRIEF.md
# Full-Page Burst Column Sequencer

This block sequences the column side of one open row in a synchronous DRAM bank when the burst length is a full page. A command arrives on every clock: NOP, ACTIVATE, WRITE, READ, BURST STOP or PRECHARGE. WRITE and READ carry a start column. From that column the block advances one column per clock, wrapping modulo the page size, until it is stopped. It drives a write strobe and column into a behavioural page array. Read beats return array data after a parameterised CAS latency.

A full-page burst never ends by itself. Only BURST STOP or PRECHARGE ends it. A write burst stops on the very edge that carries BURST STOP, so that edge writes nothing, at either latency. After a BURST STOP that ends a burst, a timer expects PRECHARGE within a maximum active window and raises a sticky violation flag if the window runs out.

The controller has four states: IDLE, OPEN (row active, no burst), WBURST and RBURST. Its transitions are:
- IDLE to OPEN on ACTIVATE.
- OPEN to WBURST on WRITE, and OPEN to RBURST on READ.
- WBURST or RBURST to the other burst state on WRITE or READ, which restarts at the new column.
- WBURST or RBURST back to OPEN on BURST STOP.
- OPEN, WBURST or RBURST to IDLE on PRECHARGE.

Top module: `fullpage_col_seq`

## Requirements
- R1: After reset the bank is IDLE. wr_en_o, rvalid_o, illegal_o and tras_viol_o are all 0.
- R2: In OPEN or in a burst, a WRITE command (cmd_i=2) writes wdata_i at col_i in the same cycle (wr_en_o=1, col_o=col_i). Each later cycle of the write burst writes that cycle's wdata_i at the next column.
- R3: Burst columns advance by one per cycle modulo 256 from any start column. After 256 beats the column is back at the start and keeps going.
- R4: A BURST STOP (cmd_i=4) during a write burst writes nothing in its own cycle or afterwards, for CAS latency 2 or 3. The bank goes to OPEN.
- R5: A READ command (cmd_i=3) issues beats from col_i, one column per cycle, until it is stopped. The array word for a beat issued at edge E shows on rdata_o with rvalid_o=1 after edge E+CAS_LAT-1. Beats issued before a stop are still delivered.
- R6: WRITE or READ while IDLE sets illegal_o in that cycle and causes no write and no read.
- R7: PRECHARGE (cmd_i=5) returns the bank to IDLE and cancels any running burst. No further beats are issued.
- R8: A BURST STOP with no burst running, and an ACTIVATE (cmd_i=1) while the row is already open, change nothing. The state stays the same and the timer is not started.
- R9: tras_viol_o rises after the TRAS_MAX-th edge following a burst-ending BURST STOP if no PRECHARGE came on any of those edges. It stays high until a PRECHARGE edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACTIVATE, 2 WRITE, 3 READ, 4 BURST STOP, 5 PRECHARGE |
| col_i | input | COL_W | Start column for WRITE/READ |
| wdata_i | input | DATA_W | Write data for the current cycle |
| col_o | output | COL_W | Column of the current beat |
| wr_en_o | output | 1 | Current cycle is a write beat |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | rdata_o is valid |
| illegal_o | output | 1 | WRITE/READ issued while IDLE |
| tras_viol_o | output | 1 | Sticky: PRECHARGE missed after burst stop |

## Verification
The bench drives a write burst that starts six columns below the top of the page and runs past 256 beats. A counter that saturates, or that wraps to column 0 instead of continuing, leaves the wrong data, which the following wrapped read burst exposes. The bench stops that burst with BURST STOP at CAS latency 3. A design that applied a latency-dependent delay to the stop would still raise the write strobe on the stop edge. The bench also switches between read and write mid-burst and precharges in the middle of bursts. It then waits out the active window once with a PRECHARGE in time and once without, so a timer that is off by one edge, or that starts on a BURST STOP with no burst running, flags at the wrong cycle.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_WR  = 3'd2,
        CMD_RD  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_WBURST,
        ST_RBURST
    } bank_st_e;
endpackage

// File: rtl/fpcs_col_ctrl.sv
module fpcs_col_ctrl
    import fpcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_col,
    output logic             wr_beat,
    output logic             rd_beat,
    output logic             illegal,
    output logic             burst_stop
);
    bank_st_e         st_q, st_d;
    logic [COL_W-1:0] col_q;
    logic             start;
    cmd_e             c;

    assign c = cmd_e'(cmd);

    // state and column register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            col_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_beat || rd_beat)
                col_q <= beat_col + COL_W'(1);
        end
    end

    // next state and beat outputs
    always_comb begin
        st_d       = st_q;
        wr_beat    = 1'b0;
        rd_beat    = 1'b0;
        start      = 1'b0;
        illegal    = 1'b0;
        burst_stop = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (c == CMD_ACT)
                    st_d = ST_OPEN;
                else if (c == CMD_WR || c == CMD_RD)
                    illegal = 1'b1;
            end
            ST_OPEN: begin
                case (c)
                    CMD_WR:  begin wr_beat = 1'b1; start = 1'b1; st_d = ST_WBURST; end
                    CMD_RD:  begin rd_beat = 1'b1; start = 1'b1; st_d = ST_RBURST; end
                    CMD_PRE: st_d = ST_IDLE;
                    default: st_d = ST_OPEN;
                endcase
            end
            ST_WBURST, ST_RBURST: begin
                case (c)
                    CMD_WR:  begin wr_beat = 1'b1; start = 1'b1; st_d = ST_WBURST; end
                    CMD_RD:  begin rd_beat = 1'b1; start = 1'b1; st_d = ST_RBURST; end
                    CMD_BST: begin burst_stop = 1'b1; st_d = ST_OPEN; end
                    CMD_PRE: st_d = ST_IDLE;
                    default: begin
                        wr_beat = (st_q == ST_WBURST);
                        rd_beat = (st_q == ST_RBURST);
                    end
                endcase
            end
        endcase
        beat_col = start ? start_col : col_q;
    end
endmodule

// File: rtl/fpcs_page.sv
module fpcs_page #(
    parameter int COL_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int PAGE = 1 << COL_W;

    logic [DATA_W-1:0] mem [PAGE];
    logic [CAS_LAT-1:0] vld_q;
    logic [DATA_W-1:0]  dat_q [CAS_LAT];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[col] <= wdata;
        dat_q[0] <= mem[col];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q[0] <= 1'b0;
        else        vld_q[0] <= rd_en;
    end

    for (genvar i = 1; i < CAS_LAT; i++) begin : g_lat
        always_ff @(posedge clk) begin
            dat_q[i] <= dat_q[i-1];
            if (!rst_n) vld_q[i] <= 1'b0;
            else        vld_q[i] <= vld_q[i-1];
        end
    end

    assign rdata  = dat_q[CAS_LAT-1];
    assign rvalid = vld_q[CAS_LAT-1];
endmodule

// File: rtl/fpcs_tras_timer.sv
module fpcs_tras_timer #(
    parameter int TRAS_MAX = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    output logic viol
);
    localparam int CNT_W = $clog2(TRAS_MAX + 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            viol    <= 1'b0;
        end else if (clear) begin
            armed_q <= 1'b0;
            viol    <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q) begin
            if (cnt_q == CNT_W'(TRAS_MAX - 1)) begin
                viol    <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/fullpage_col_seq.sv
module fullpage_col_seq
    import fpcs_pkg::*;
#(
    parameter int COL_W    = 8,
    parameter int DATA_W   = 16,
    parameter int CAS_LAT  = 2,
    parameter int TRAS_MAX = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [COL_W-1:0]  col_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              illegal_o,
    output logic              tras_viol_o
);
    logic rd_beat;
    logic stop_evt;

    fpcs_col_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd_i),
        .start_col  (col_i),
        .beat_col   (col_o),
        .wr_beat    (wr_en_o),
        .rd_beat    (rd_beat),
        .illegal    (illegal_o),
        .burst_stop (stop_evt)
    );

    fpcs_page #(.COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_o),
        .rd_en  (rd_beat),
        .col    (col_o),
        .wdata  (wdata_i),
        .rdata  (rdata_o),
        .rvalid (rvalid_o)
    );

    fpcs_tras_timer #(.TRAS_MAX(TRAS_MAX)) u_tras (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (stop_evt),
        .clear (cmd_i == CMD_PRE),
        .viol  (tras_viol_o)
    );
endmodule

// File: rtl/fpcs_chk.sv
module fpcs_chk
    import fpcs_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int CAS_LAT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_i,
    input logic [COL_W-1:0] col_o,
    input logic             wr_en_o,
    input logic             rvalid_o,
    input logic             illegal_o,
    input logic             tras_viol_o,
    input logic             rd_issue
);
    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o) && cmd_i != CMD_WR)
            |-> col_o == COL_W'($past(col_o) + COL_W'(1)));

    p_bst_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BST) |-> !wr_en_o);

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o == $past(rd_issue, CAS_LAT));

    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !rd_issue));

    p_pre_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_i) == CMD_PRE && cmd_i == CMD_NOP) |-> (!wr_en_o && !rd_issue));

    p_viol_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_i) == CMD_PRE) |-> !tras_viol_o);
endmodule

bind fullpage_col_seq fpcs_chk #(.COL_W(COL_W), .CAS_LAT(CAS_LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .col_o       (col_o),
    .wr_en_o     (wr_en_o),
    .rvalid_o    (rvalid_o),
    .illegal_o   (illegal_o),
    .tras_viol_o (tras_viol_o),
    .rd_issue    (rd_beat)
);

// File: tb/sim_fullpage_col_seq.sv
module sim_fullpage_col_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CL   = 3;
    localparam int TMAX = 20;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, WR = 3'd2, RD = 3'd3, BST = 3'd4, PRE = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = NOP;
    logic [7:0]  coli = '0;
    logic [15:0] wd = '0;
    logic [7:0]  col_o;
    logic        wr_en_o, rvalid_o, illegal_o, tras_viol_o;
    logic [15:0] rdata_o;

    int nvec = 0;
    int nfail = 0;

    // behavioural model
    int          m_st = 0;      // 0 idle, 1 open, 2 write burst, 3 read burst
    int          m_ctr = 0;
    logic [15:0] m_mem [256];
    bit          pv [$];
    logic [15:0] pd [$];
    bit          m_armed = 0;
    int          m_tcnt = 0;
    bit          m_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fullpage_col_seq #(.COL_W(8), .DATA_W(16), .CAS_LAT(CL), .TRAS_MAX(TMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(coli), .wdata_i(wd),
        .col_o(col_o), .wr_en_o(wr_en_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .illegal_o(illegal_o), .tras_viol_o(tras_viol_o)
    );

    function automatic logic [15:0] dat(input int i);
        return 16'(i * 40503) ^ 16'h5a5a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [2:0] c, input int col, input logic [15:0] d);
        bit ew, er, eill, start, stop;
        int bc;
        @(negedge clk);
        cmd = c; coli = col[7:0]; wd = d;
        #2;
        ew = 0; er = 0; eill = 0; start = 0; stop = 0;
        case (m_st)
            0: eill = (c == WR || c == RD);
            1: begin ew = (c == WR); er = (c == RD); start = ew || er; end
            default: begin
                if (c == WR || c == RD) begin
                    ew = (c == WR); er = (c == RD); start = 1;
                end else if (c == BST) stop = 1;
                else if (c != PRE) begin ew = (m_st == 2); er = (m_st == 3); end
            end
        endcase
        bc = start ? col : m_ctr;
        chk(wr_en_o === ew, "R2/R4/R7", "wr_en_o", 32'(wr_en_o), 32'(ew));
        if (ew || er) chk(col_o === 8'(bc), "R3", "col_o", 32'(col_o), 32'(bc));
        chk(illegal_o === eill, "R6", "illegal_o", 32'(illegal_o), 32'(eill));
        chk(rvalid_o === pv[$], "R5", "rvalid_o", 32'(rvalid_o), 32'(pv[$]));
        if (pv[$]) chk(rdata_o === pd[$], "R5", "rdata_o", 32'(rdata_o), 32'(pd[$]));
        chk(tras_viol_o === m_viol, "R9", "tras_viol_o", 32'(tras_viol_o), 32'(m_viol));
        @(posedge clk);
        // model update for this edge
        pv.push_front(er); pd.push_front(er ? m_mem[bc[7:0]] : 16'h0);
        void'(pv.pop_back()); void'(pd.pop_back());
        if (ew) m_mem[bc[7:0]] = d;
        if (ew || er) m_ctr = (bc + 1) % 256;
        if (c == PRE) begin m_armed = 0; m_viol = 0; end
        else if (stop) begin m_armed = 1; m_tcnt = 0; end
        else if (m_armed) begin
            if (m_tcnt == TMAX - 1) begin m_viol = 1; m_armed = 0; end
            else m_tcnt++;
        end
        case (m_st)
            0: if (c == ACT) m_st = 1;
            1: if (c == WR) m_st = 2; else if (c == RD) m_st = 3; else if (c == PRE) m_st = 0;
            default: if (c == WR) m_st = 2; else if (c == RD) m_st = 3;
                     else if (c == BST) m_st = 1; else if (c == PRE) m_st = 0;
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < CL; i++) begin pv.push_back(0); pd.push_back(16'h0); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(wr_en_o === 1'b0, "R1", "wr_en_o", 32'(wr_en_o), 0);
        chk(rvalid_o === 1'b0, "R1", "rvalid_o", 32'(rvalid_o), 0);
        chk(illegal_o === 1'b0, "R1", "illegal_o", 32'(illegal_o), 0);
        chk(tras_viol_o === 1'b0, "R1", "tras_viol_o", 32'(tras_viol_o), 0);

        // R6: burst commands while idle; R8: stop with no burst
        step(WR, 5, 16'h1111);
        step(RD, 6, 16'h0);
        step(BST, 0, 16'h0);
        step(PRE, 0, 16'h0);
        step(NOP, 0, 16'h0);

        // R8: open row, stray stop and activate, timer must stay quiet
        step(ACT, 0, 16'h0);
        step(BST, 0, 16'h0);
        repeat (TMAX + 5) step(NOP, 0, 16'h0);
        step(ACT, 0, 16'h0);

        // R2/R3/R4: write burst from 250 wrapping past the page, stopped
        step(WR, 250, dat(0));
        for (int i = 1; i < 260; i++) step(NOP, 0, dat(i));
        step(BST, 0, dat(999));
        repeat (3) step(NOP, 0, dat(998));
        step(PRE, 0, 16'h0);    // R9: precharge in time
        repeat (TMAX + 2) step(NOP, 0, 16'h0);

        // R5/R3: wrapped read burst, then missing precharge (R9)
        step(ACT, 0, 16'h0);
        step(RD, 248, 16'h0);
        for (int i = 0; i < 261; i++) step(NOP, 0, 16'h0);
        step(BST, 0, 16'h0);
        repeat (TMAX + 5) step(NOP, 0, 16'h0);
        step(PRE, 0, 16'h0);
        step(NOP, 0, 16'h0);

        // mid-burst switches, restart, and R7 cancellation
        step(ACT, 0, 16'h0);
        step(WR, 16, dat(300));
        for (int i = 1; i < 8; i++) step(NOP, 0, dat(300 + i));
        step(RD, 14, 16'h0);
        repeat (5) step(NOP, 0, 16'h0);
        step(WR, 100, dat(400));
        step(NOP, 0, dat(401));
        step(BST, 0, dat(402));
        step(WR, 200, dat(403));
        step(NOP, 0, dat(404));
        step(PRE, 0, dat(405));
        repeat (5) step(NOP, 0, dat(406));
        step(ACT, 0, 16'h0);
        step(RD, 98, 16'h0);
        repeat (4) step(NOP, 0, 16'h0);
        step(PRE, 0, 16'h0);
        repeat (6) step(NOP, 0, 16'h0);
        step(ACT, 0, 16'h0);
        step(RD, 199, 16'h0);
        repeat (3) step(NOP, 0, 16'h0);
        step(BST, 0, 16'h0);
        repeat (4) step(NOP, 0, 16'h0);
        step(PRE, 0, 16'h0);
        step(NOP, 0, 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule